// File: doc/BRIEF.md
# Test Cube Conflict Merger

The merger takes a stream of scan test cubes, one cube per accepted input beat. Each cube has `CUBE_LEN` positions, and each position carries a 2-bit symbol for 0, 1 or don't-care X. The block folds consecutive cubes into one merged cube. Each position of the merged cube takes one of four values. It stays X while only don't-cares have arrived. It takes the specified value once a 0 or a 1 arrives. It becomes a conflict U as soon as both a 0 and a 1 have been seen at that position. A conflict is never cleared again within the group.

A group holds a selectable number of cubes: 5, 10 or 15. When the last cube of a group is accepted, the block closes the group. It presents the merged cube, the number of conflict positions, the number of non-conflict positions and the number of cubes that went into it. A flush request closes a partial group early, for example at the end of a pattern list. Fewer conflict positions mean that more of the group can be shifted in as one compressed pattern. The conflict tally is therefore the figure of merit that a host compares across cluster sizes.

The result is held on a valid/ready output. While a result waits to be taken, the cube input is stalled.

Top module: `tcm_merger`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. Symbols are coded per position `p` in bits `[2p+1:2p]` as 00 = 0, 01 = 1, 10 = X and 11 = U.
- R2: A merged position is 00 (0) when the group's cubes hold only 0 or X there, with at least one 0.
- R3: A merged position is 01 (1) when the group's cubes hold only 1 or X there, with at least one 1.
- R4: A merged position is 10 (X) when every cube of the group holds X there.
- R5: A merged position is 11 (U) once the group has shown both a 0 and a 1 there, whatever follows later in the group. An input symbol of 11 also forces U.
- R6: `size_code` selects the group length: 00 = 5, 01 = 10, 10 = 15 and 11 = 15. It is sampled on the first accepted cube of a group and held for the rest of that group. On the accepting edge of the group's last cube, `out_valid` rises, and `out_fill` then equals the group length.
- R7: With a result, `out_conflicts` equals the number of U positions in `out_cube`, and `out_clean` equals `CUBE_LEN - out_conflicts`.
- R8: `flush` closes a partial group. If it comes with an accepted cube, that cube is included. If it comes without one, the group closes as it stands. `out_fill` gives the actual cube count. A flush on an empty group produces no result.
- R9: While `out_valid` is 1, `in_ready` is 0, and the result stays unchanged until `out_ready` is 1 at a clock edge.
- R10: After a group closes, the next group starts from all-X. No symbol carries over between groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| size_code | input | 2 | Group length select, sampled at group start |
| in_valid | input | 1 | Cube present on `in_cube` |
| in_ready | output | 1 | Block can take a cube |
| in_cube | input | 2*CUBE_LEN | Incoming cube, 2 bits per position |
| flush | input | 1 | Close the current group early |
| out_valid | output | 1 | Merged result present |
| out_ready | input | 1 | Consumer takes the result |
| out_cube | output | 2*CUBE_LEN | Merged cube, 2 bits per position |
| out_conflicts | output | $clog2(CUBE_LEN+1) | Number of U positions |
| out_clean | output | $clog2(CUBE_LEN+1) | Number of non-U positions |
| out_fill | output | $clog2(SIZE_C+1) | Cubes merged into the result |

## Verification
A hand-built five-cube group places, at separate positions, each of the four outcomes:
- a 0 among don't-cares;
- a 1 among don't-cares;
- don't-cares only;
- early and late 0/1 clashes, so a wrong merge is traced to one rule.

Pseudo-random cubes biased toward X fill the 10- and 15-cube groups, and `size_code` is changed in the middle of a group. This shows whether the length is latched at group start or taken live. Partial groups are closed by a flush with a cube and by a flush without one, and a flush on an empty group must yield nothing. An all-X cube that follows a conflict-heavy group exposes any state carried between groups. The output is stalled on a repeating pattern throughout, which exercises the hold and intake stall.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

   typedef enum logic [1:0] {
      SYM_ZERO = 2'b00,
      SYM_ONE  = 2'b01,
      SYM_X    = 2'b10,
      SYM_U    = 2'b11
   } sym_t;

   // Fold one incoming symbol into an accumulated one.
   function automatic logic [1:0] fold_sym(input logic [1:0] acc, input logic [1:0] din);
      logic [1:0] res;
      if (acc == SYM_X)      res = din;
      else if (din == SYM_X) res = acc;
      else if (acc == din)   res = acc;
      else                   res = SYM_U;
      return res;
   endfunction

   // Group length for a size select code.
   function automatic int unsigned size_of(input logic [1:0] code, input int unsigned sa,
                                           input int unsigned sb, input int unsigned sc);
      int unsigned n;
      case (code)
         2'b00:   n = sa;
         2'b01:   n = sb;
         default: n = sc;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tcm_lane.sv
module tcm_lane
   import tcm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take,
   input  logic       restart,
   input  logic [1:0] din,
   output logic [1:0] acc_q,
   output logic [1:0] fold
);

   assign fold = fold_sym(acc_q, din);

   always_ff @(posedge clk) begin
      if (!rst_n)       acc_q <= SYM_X;
      else if (restart) acc_q <= SYM_X;
      else if (take)    acc_q <= fold;
   end

   assert_u_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !restart && acc_q == SYM_U) |=> (acc_q == SYM_U));

   assert_x_neutral_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !restart && din == SYM_X) |=> (acc_q == $past(acc_q)));

   assert_clash_to_u_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !restart && ((acc_q == SYM_ZERO && din == SYM_ONE) ||
                            (acc_q == SYM_ONE && din == SYM_ZERO))) |=> (acc_q == SYM_U));

   assert_start_all_x_R10: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (acc_q == SYM_X));

endmodule

// File: rtl/tcm_usum.sv
module tcm_usum #(
   parameter int unsigned N     = 8,
   parameter int unsigned W     = 4,
   parameter int unsigned STYLE = 0
) (
   input  logic [N-1:0] flags,
   output logic [W-1:0] total
);

   if (W < $clog2(N + 1)) begin : g_bad_width
      $error("tcm_usum: W too narrow for N");
   end

   if (STYLE == 0) begin : g_loop
      always_comb begin
         total = '0;
         for (int i = 0; i < N; i++) total = total + W'(flags[i]);
      end
   end else begin : g_chain
      logic [W-1:0] part [N+1];
      assign part[0] = '0;
      for (genvar gi = 0; gi < N; gi++) begin : g_step
         assign part[gi+1] = part[gi] + W'(flags[gi]);
      end
      assign total = part[N];
   end

endmodule

// File: rtl/tcm_group_ctrl.sv
module tcm_group_ctrl
   import tcm_pkg::*;
#(
   parameter int unsigned SIZE_A = 5,
   parameter int unsigned SIZE_B = 10,
   parameter int unsigned SIZE_C = 15,
   parameter int unsigned NW     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          in_valid,
   input  logic          in_ready,
   input  logic          flush,
   input  logic [1:0]    size_code,
   output logic          close,
   output logic [NW-1:0] fill_n
);

   if (SIZE_A < 1 || SIZE_B < 1 || SIZE_C < 1) begin : g_bad_size
      $error("tcm_group_ctrl: group sizes must be at least 1");
   end
   if (SIZE_A >= 2**NW || SIZE_B >= 2**NW || SIZE_C >= 2**NW) begin : g_bad_nw
      $error("tcm_group_ctrl: NW too narrow for group sizes");
   end

   logic [NW-1:0] cnt_q;
   logic [NW-1:0] lim_q;
   logic [NW-1:0] lim_now;
   logic          last_cube;
   logic          bare_flush;

   assign lim_now    = (cnt_q == '0) ? NW'(size_of(size_code, SIZE_A, SIZE_B, SIZE_C)) : lim_q;
   assign last_cube  = (cnt_q + 1'b1) == lim_now;
   assign bare_flush = flush && in_ready && !in_valid && (cnt_q != '0);
   assign close      = (take && (last_cube || flush)) || bare_flush;
   assign fill_n     = take ? cnt_q + 1'b1 : cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= NW'(SIZE_A);
      end else begin
         if (close)     cnt_q <= '0;
         else if (take) cnt_q <= cnt_q + 1'b1;
         if (take && cnt_q == '0) lim_q <= lim_now;
      end
   end

   assert_fill_below_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> (cnt_q < lim_q));

   assert_restart_after_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
      close |=> (cnt_q == '0));

   assert_empty_flush_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !in_valid && cnt_q == '0) |=> (cnt_q == '0));

   assert_limit_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && !close) |=> (lim_q == $past(lim_q)));

endmodule

// File: rtl/tcm_merger.sv
module tcm_merger
   import tcm_pkg::*;
#(
   parameter int unsigned CUBE_LEN    = 8,
   parameter int unsigned SIZE_A      = 5,
   parameter int unsigned SIZE_B      = 10,
   parameter int unsigned SIZE_C      = 15,
   parameter int unsigned COUNT_STYLE = 0,
   localparam int unsigned LW = 2 * CUBE_LEN,
   localparam int unsigned CW = $clog2(CUBE_LEN + 1),
   localparam int unsigned NW = $clog2(SIZE_C + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    size_code,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [LW-1:0] in_cube,
   input  logic          flush,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [LW-1:0] out_cube,
   output logic [CW-1:0] out_conflicts,
   output logic [CW-1:0] out_clean,
   output logic [NW-1:0] out_fill
);

   if (CUBE_LEN < 1) begin : g_bad_len
      $error("tcm_merger: CUBE_LEN must be at least 1");
   end
   if (SIZE_C < SIZE_A || SIZE_C < SIZE_B) begin : g_bad_order
      $error("tcm_merger: SIZE_C must be the largest group size");
   end

   logic                take;
   logic                close;
   logic [NW-1:0]       fill_n;
   logic [LW-1:0]       acc_vec;
   logic [LW-1:0]       fold_vec;
   logic [LW-1:0]       snap_vec;
   logic [CUBE_LEN-1:0] u_flag;
   logic [CW-1:0]       u_cnt;

   assign in_ready = !out_valid;
   assign take     = in_valid && in_ready;

   tcm_group_ctrl #(
      .SIZE_A (SIZE_A),
      .SIZE_B (SIZE_B),
      .SIZE_C (SIZE_C),
      .NW     (NW)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .flush     (flush),
      .size_code (size_code),
      .close     (close),
      .fill_n    (fill_n)
   );

   for (genvar gp = 0; gp < CUBE_LEN; gp++) begin : g_lane
      tcm_lane u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .take    (take),
         .restart (close),
         .din     (in_cube[2*gp +: 2]),
         .acc_q   (acc_vec[2*gp +: 2]),
         .fold    (fold_vec[2*gp +: 2])
      );
      assign u_flag[gp] = (snap_vec[2*gp +: 2] == SYM_U);
   end

   // Closing value: includes the cube on the closing beat if one is taken.
   assign snap_vec = take ? fold_vec : acc_vec;

   tcm_usum #(
      .N     (CUBE_LEN),
      .W     (CW),
      .STYLE (COUNT_STYLE)
   ) u_usum (
      .flags (u_flag),
      .total (u_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_cube      <= '0;
         out_conflicts <= '0;
         out_clean     <= '0;
         out_fill      <= '0;
      end else if (close) begin
         out_valid     <= 1'b1;
         out_cube      <= snap_vec;
         out_conflicts <= u_cnt;
         out_clean     <= CW'(CUBE_LEN) - u_cnt;
         out_fill      <= fill_n;
      end else if (out_ready) begin
         out_valid     <= 1'b0;
      end
   end

   function automatic int unsigned u_in(input logic [LW-1:0] cube);
      int unsigned n;
      n = 0;
      for (int i = 0; i < CUBE_LEN; i++) if (cube[2*i +: 2] == SYM_U) n++;
      return n;
   endfunction

   assert_hold_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_cube) && $stable(out_fill)
                                     && $stable(out_conflicts)));

   assert_count_split_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((CW+1)'(out_conflicts) + (CW+1)'(out_clean) == (CW+1)'(CUBE_LEN)));

   assert_conflict_tally_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_conflicts) == int'(u_in(out_cube))));

   assert_fill_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_fill != '0 && out_fill <= NW'(SIZE_C)));

endmodule

// File: tb/tcm_merger_tb.sv
`timescale 1ns/1ps
module tcm_merger_tb;

   localparam int L  = 8;
   localparam int LW = 2 * L;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    size_code = 2'b00;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [LW-1:0] in_cube = '0;
   logic          flush = 1'b0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [LW-1:0] out_cube;
   logic [3:0]    out_conflicts;
   logic [3:0]    out_clean;
   logic [3:0]    out_fill;

   always #5 clk = ~clk;

   tcm_merger u_dut (
      .clk(clk), .rst_n(rst_n), .size_code(size_code),
      .in_valid(in_valid), .in_ready(in_ready), .in_cube(in_cube), .flush(flush),
      .out_valid(out_valid), .out_ready(out_ready), .out_cube(out_cube),
      .out_conflicts(out_conflicts), .out_clean(out_clean), .out_fill(out_fill)
   );

   typedef struct {
      logic [LW-1:0] cube;
      int            conf;
      int            fill;
      string         tag;
   } exp_t;

   exp_t  sb[$];
   int    checks = 0;
   int    errors = 0;
   bit    seen0 [L];
   bit    seen1 [L];
   int    grp_n = 0;
   int    grp_lim = 5;
   bit    live = 1'b0;
   bit    finished = 1'b0;
   logic [31:0] lfsr = 32'h1ACE_5EED;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [LW-1:0] mk(input string s);
      logic [LW-1:0] c;
      for (int p = 0; p < L; p++) begin
         case (s[p])
            "0":     c[2*p +: 2] = 2'b00;
            "1":     c[2*p +: 2] = 2'b01;
            "U":     c[2*p +: 2] = 2'b11;
            default: c[2*p +: 2] = 2'b10;
         endcase
      end
      return c;
   endfunction

   function automatic logic [LW-1:0] rnd_cube();
      logic [LW-1:0] c;
      for (int p = 0; p < L; p++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         case (lfsr[3:1])
            3'd0:    c[2*p +: 2] = 2'b00;
            3'd1:    c[2*p +: 2] = 2'b01;
            default: c[2*p +: 2] = 2'b10;
         endcase
      end
      return c;
   endfunction

   function automatic int size_for(input logic [1:0] code);
      return (code == 2'b00) ? 5 : (code == 2'b01) ? 10 : 15;
   endfunction

   task automatic model_emit(input string tag);
      exp_t e;
      e.conf = 0;
      for (int p = 0; p < L; p++) begin
         if (seen0[p] && seen1[p]) begin e.cube[2*p +: 2] = 2'b11; e.conf++; end
         else if (seen0[p])        e.cube[2*p +: 2] = 2'b00;
         else if (seen1[p])        e.cube[2*p +: 2] = 2'b01;
         else                      e.cube[2*p +: 2] = 2'b10;
         seen0[p] = 1'b0;
         seen1[p] = 1'b0;
      end
      e.fill = grp_n;
      e.tag  = tag;
      sb.push_back(e);
      grp_n = 0;
   endtask

   task automatic send(input logic [LW-1:0] cube, input bit fl, input logic [1:0] sel,
                       input string tag);
      @(negedge clk);
      in_valid  = 1'b1;
      in_cube   = cube;
      flush     = fl;
      size_code = sel;
      while (!in_ready) @(negedge clk);
      if (grp_n == 0) grp_lim = size_for(sel);
      for (int p = 0; p < L; p++) begin
         if (cube[2*p +: 2] == 2'b00) seen0[p] = 1'b1;
         if (cube[2*p +: 2] == 2'b01) seen1[p] = 1'b1;
         if (cube[2*p +: 2] == 2'b11) begin seen0[p] = 1'b1; seen1[p] = 1'b1; end
      end
      grp_n++;
      if (grp_n == grp_lim || fl) model_emit(tag);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      flush    = 1'b0;
   endtask

   task automatic flush_only();
      @(negedge clk);
      in_valid = 1'b0;
      flush    = 1'b1;
      while (!in_ready) @(negedge clk);
      if (grp_n != 0) model_emit("R8");
      @(posedge clk);
      #1;
      flush = 1'b0;
   endtask

   // Output consumer: stalls on a repeating pattern, changed away from the edges.
   initial begin
      int k;
      k = 0;
      forever begin
         @(posedge clk);
         #2;
         k++;
         out_ready = (k % 9) < 5;
      end
   end

   // Monitor / scoreboard.
   initial begin
      bit            prev_pend;
      logic [LW-1:0] prev_cube;
      exp_t          e;
      string         t;
      prev_pend = 1'b0;
      prev_cube = '0;
      forever begin
         @(negedge clk);
         if (live) begin
            if (out_valid) chk(in_ready == 1'b0, "R9 intake stalled", in_ready, 0);
            if (prev_pend) chk(out_valid && out_cube == prev_cube, "R9 result held",
                               out_cube, prev_cube);
            if (out_valid && out_ready) begin
               if (sb.size() == 0) begin
                  chk(1'b0, "R8 unexpected result", out_fill, 0);
               end else begin
                  e = sb.pop_front();
                  for (int p = 0; p < L; p++) begin
                     case (e.cube[2*p +: 2])
                        2'b00:   t = "R2 merged 0";
                        2'b01:   t = "R3 merged 1";
                        2'b10:   t = "R4 merged X";
                        default: t = "R5 merged U";
                     endcase
                     if (e.tag == "R10") t = "R10 fresh group";
                     chk(out_cube[2*p +: 2] == e.cube[2*p +: 2], t,
                         out_cube[2*p +: 2], e.cube[2*p +: 2]);
                  end
                  chk(int'(out_conflicts) == e.conf, "R7 conflicts", out_conflicts, e.conf);
                  chk(int'(out_clean) == L - e.conf, "R7 clean", out_clean, L - e.conf);
                  chk(int'(out_fill) == e.fill, {e.tag, " fill"}, out_fill, e.fill);
               end
            end
            prev_pend = out_valid && !out_ready;
            prev_cube = out_cube;
         end
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", sb.size());
      summary();
   end

   initial begin
      for (int p = 0; p < L; p++) begin seen0[p] = 1'b0; seen1[p] = 1'b0; end
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
      chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
      live = 1'b1;

      // Crafted group of 5: each position exercises one merge rule.
      send(mk("01X01XX1"), 0, 2'b00, "R6");
      send(mk("XXX10X01"), 0, 2'b00, "R6");
      send(mk("01XX0XX1"), 0, 2'b00, "R6");
      send(mk("X1XX0X11"), 0, 2'b00, "R6");
      send(mk("XXXX00X1"), 0, 2'b00, "R6");

      // Group of 10; select changed mid-group must be ignored (R6).
      for (int i = 0; i < 10; i++) send(rnd_cube(), 0, (i < 3) ? 2'b01 : 2'b00, "R6");
      // Groups of 15 via codes 10 and 11.
      for (int i = 0; i < 15; i++) send(rnd_cube(), 0, 2'b10, "R6");
      for (int i = 0; i < 15; i++) send(rnd_cube(), 0, 2'b11, "R6");

      // Conflict-heavy group, then an all-X cube flushed alone (R10).
      send(mk("01010101"), 0, 2'b00, "R6");
      send(mk("10101010"), 0, 2'b00, "R6");
      send(mk("UUUUUUUU"), 0, 2'b00, "R6");
      send(mk("0X1X0X1X"), 0, 2'b00, "R6");
      send(mk("XXXXXXXX"), 0, 2'b00, "R6");
      send(mk("XXXXXXXX"), 1, 2'b01, "R10");

      // Partial groups closed by flush without and with a cube (R8).
      for (int i = 0; i < 3; i++) send(rnd_cube(), 0, 2'b01, "R8");
      flush_only();
      for (int i = 0; i < 4; i++) send(rnd_cube(), (i == 3), 2'b10, "R8");

      // Flush on an empty group must produce nothing (R8).
      while (sb.size() != 0 || out_valid) @(negedge clk);
      flush_only();
      repeat (4) @(negedge clk);
      chk(out_valid == 1'b0, "R8 empty flush no result", out_valid, 0);

      // Back-to-back random groups under output stalls.
      for (int i = 0; i < 20; i++) send(rnd_cube(), 0, 2'b00, "R6");
      while (sb.size() != 0 || out_valid) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(sb.size() == 0, "R6 all results seen", sb.size(), 0);
      summary();
   end

endmodule